// File: doc/BRIEF.md
# Placeholder Outer-Cache Control Register Window

This block sits where an outer-level cache controller would normally be mapped and answers its 4 KB register window with believable contents, so that boot code and drivers can identify, enable, tune and "flush" a cache that does not exist. It keeps the enable bit, an auxiliary configuration word, two latency words and a pair of address-filter bounds. It also returns a fixed identity word and a type word that picks up way and size information from the auxiliary configuration each time it is read.

The block is reached through a simple synchronous port with address, write data, write strobe, read strobe and registered read data. Maintenance-operation offsets always read back as finished, and a few debug and power offsets are accepted without effect. Any offset outside the known set reads as zero, drops its write data and produces a single-cycle illegal-access pulse.

Top module: `cache_reg_stub`

## Requirements
- R1: Only address bits 11:0 select a register, so an access at any address reaches the same register as the address with bits above 11 cleared.
- R2: Every offset from 0x730 up to and including 0x7FC reads as zero, discards writes and raises no illegal-access pulse.
- R3: Offset 0x000 reads 0x410000C8; a write there changes nothing and is flagged as illegal.
- R4: A read of offset 0x004 builds a 5-bit value v with v[4:2] = aux[19:17], v[1] = 0, v[0] = aux[16], ORs v into the stored type word at bit 18 and at bit 6, stores the result and returns it; bits once set stay set.
- R5: The type word starts at parameter TYPE_INIT (default 0x1C100100) and reset leaves it unchanged; a write to 0x004 has no effect and is flagged as illegal.
- R6: The enable register at 0x100 stores write data bit 0 only; its bits 31:1 read as zero.
- R7: Auxiliary (0x104), tag latency (0x108), data latency (0x10C), filter start (0xC00) and filter end (0xC04) store and return all 32 written bits.
- R8: Synchronous reset sets auxiliary to 0x02020000 and the enable, both latency and both filter registers to zero, and clears the read data and illegal-access outputs.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as zero, ignore writes and raise no illegal-access pulse.
- R10: Every other offset reads as zero, ignores writes and is flagged as illegal.
- R11: Read data appears on the clock edge after an accepted read and holds its value through cycles with no accepted read.
- R12: The illegal-access output is high for exactly the one cycle after each flagged access and low otherwise.
- R13: A cycle with both strobes high is a write only: read data holds and the type word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle illegal-access pulse |

## Verification
The hardest condition to reach is proof that a simultaneous read and write did not fold the auxiliary bits into the type word, because the type word only becomes visible through a read, and that read performs the same merge. The stimulus therefore loads auxiliary bits that are not yet present in the type word, issues the collision, clears the auxiliary register and only then reads the type word, so any stray merge shows up as extra bits. The saturating merge is reached only afterwards, since once every mergeable bit is set the type word can no longer reveal a side effect.

// File: rtl/ccstub_pkg.sv
package ccstub_pkg;

    localparam int OFS_W = 12;
    localparam int DW    = 32;

    localparam logic [DW-1:0] ID_WORD  = 32'h4100_00C8;
    localparam logic [DW-1:0] AUX_RST  = 32'h0202_0000;

    localparam logic [OFS_W-1:0] OFS_ID     = 12'h000;
    localparam logic [OFS_W-1:0] OFS_TYPE   = 12'h004;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h100;
    localparam logic [OFS_W-1:0] OFS_AUX    = 12'h104;
    localparam logic [OFS_W-1:0] OFS_TAGLAT = 12'h108;
    localparam logic [OFS_W-1:0] OFS_DATLAT = 12'h10C;
    localparam logic [OFS_W-1:0] OFS_FSTART = 12'hC00;
    localparam logic [OFS_W-1:0] OFS_FEND   = 12'hC04;
    localparam logic [OFS_W-1:0] OFS_Q0     = 12'hF40;
    localparam logic [OFS_W-1:0] OFS_Q1     = 12'hF60;
    localparam logic [OFS_W-1:0] OFS_Q2     = 12'hF80;
    localparam logic [OFS_W-1:0] MAINT_LO   = 12'h730;
    localparam logic [OFS_W-1:0] MAINT_HI   = 12'h800;

    typedef enum logic [3:0] {
        SEL_ID, SEL_TYPE, SEL_CTRL, SEL_AUX, SEL_TAGLAT, SEL_DATLAT,
        SEL_FSTART, SEL_FEND, SEL_MAINT, SEL_QUIET, SEL_BAD
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic wr;
        logic rd;
    } acc_t;

    typedef struct packed {
        logic          enable;
        logic [DW-1:0] aux;
        logic [DW-1:0] taglat;
        logic [DW-1:0] datlat;
        logic [DW-1:0] fstart;
        logic [DW-1:0] fend;
    } cfg_t;

    function automatic sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        sel_e s;
        if (ofs >= MAINT_LO && ofs < MAINT_HI) begin
            s = SEL_MAINT;
        end else begin
            unique case (ofs)
                OFS_ID:     s = SEL_ID;
                OFS_TYPE:   s = SEL_TYPE;
                OFS_CTRL:   s = SEL_CTRL;
                OFS_AUX:    s = SEL_AUX;
                OFS_TAGLAT: s = SEL_TAGLAT;
                OFS_DATLAT: s = SEL_DATLAT;
                OFS_FSTART: s = SEL_FSTART;
                OFS_FEND:   s = SEL_FEND;
                OFS_Q0, OFS_Q1, OFS_Q2: s = SEL_QUIET;
                default:    s = SEL_BAD;
            endcase
        end
        return s;
    endfunction

    function automatic logic write_ok(input sel_e s);
        return !(s == SEL_ID || s == SEL_TYPE || s == SEL_BAD);
    endfunction

    function automatic logic read_ok(input sel_e s);
        return s != SEL_BAD;
    endfunction

    function automatic logic [4:0] way_size_bits(input logic [DW-1:0] aux);
        return {aux[19:17], 1'b0, aux[16]};
    endfunction

endpackage

// File: rtl/ccs_decode.sv
module ccs_decode
    import ccstub_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic             we,
    input  logic             re,
    output acc_t             acc,
    output logic             flag
);

    always_comb begin
        acc.sel = decode_ofs(ofs);
        acc.wr  = we;
        acc.rd  = re && !we;
        flag    = (acc.wr && !write_ok(acc.sel)) || (acc.rd && !read_ok(acc.sel));
    end

endmodule

// File: rtl/ccs_regs.sv
module ccs_regs
    import ccstub_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  acc_t          acc,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.enable <= 1'b0;
            cfg.aux    <= AUX_RST;
            cfg.taglat <= '0;
            cfg.datlat <= '0;
            cfg.fstart <= '0;
            cfg.fend   <= '0;
        end else if (acc.wr) begin
            case (acc.sel)
                SEL_CTRL:   cfg.enable <= wdata[0];
                SEL_AUX:    cfg.aux    <= wdata;
                SEL_TAGLAT: cfg.taglat <= wdata;
                SEL_DATLAT: cfg.datlat <= wdata;
                SEL_FSTART: cfg.fstart <= wdata;
                SEL_FEND:   cfg.fend   <= wdata;
                default: ;
            endcase
        end
    end

    // R8: registers leave reset with their documented values
    assert_reset_vals_R8: assert property (@(posedge clk)
        $past(rst) |-> (cfg.aux == AUX_RST && !cfg.enable && cfg.taglat == '0 &&
                        cfg.datlat == '0 && cfg.fstart == '0 && cfg.fend == '0));

    // R2, R9: discarded writes leave every register untouched
    assert_quiet_write_R2: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && (acc.sel == SEL_MAINT || acc.sel == SEL_QUIET || acc.sel == SEL_BAD)) |=>
        $stable(cfg));

endmodule

// File: rtl/ccs_type_word.sv
module ccs_type_word
    import ccstub_pkg::*;
#(
    parameter logic [DW-1:0] TYPE_INIT = 32'h1C10_0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_type,
    input  logic          wr_any,
    input  logic [DW-1:0] aux,
    output logic [DW-1:0] type_next
);

    localparam int LO_POS = 6;
    localparam int HI_POS = 18;

    logic [DW-1:0] type_q = TYPE_INIT;
    logic [4:0]    merge;

    always_comb begin
        merge     = way_size_bits(aux);
        type_next = type_q | (DW'(merge) << HI_POS) | (DW'(merge) << LO_POS);
    end

    always_ff @(posedge clk) begin
        if (rd_type) type_q <= type_next;
    end

    // R4: merged bits never clear
    assert_type_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (type_q & $past(type_q)) == $past(type_q));

    // R13: a write cycle never updates the type word
    assert_collide_no_merge_R13: assert property (@(posedge clk) disable iff (rst)
        wr_any |=> $stable(type_q));

endmodule

// File: rtl/cache_reg_stub.sv
module cache_reg_stub
    import ccstub_pkg::*;
#(
    parameter int            ADDR_W    = 32,
    parameter logic [31:0]   TYPE_INIT = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              bad_access
);

    acc_t          acc;
    logic          flag;
    cfg_t          cfg;
    logic [DW-1:0] type_word;
    logic [DW-1:0] rd_mux;
    logic          unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];

    ccs_decode u_dec (
        .ofs  (bus_addr[OFS_W-1:0]),
        .we   (bus_we),
        .re   (bus_re),
        .acc  (acc),
        .flag (flag)
    );

    ccs_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    ccs_type_word #(.TYPE_INIT(TYPE_INIT)) u_type (
        .clk       (clk),
        .rst       (rst),
        .rd_type   (acc.rd && acc.sel == SEL_TYPE && !rst),
        .wr_any    (acc.wr),
        .aux       (cfg.aux),
        .type_next (type_word)
    );

    always_comb begin
        case (acc.sel)
            SEL_ID:     rd_mux = ID_WORD;
            SEL_TYPE:   rd_mux = type_word;
            SEL_CTRL:   rd_mux = {{(DW-1){1'b0}}, cfg.enable};
            SEL_AUX:    rd_mux = cfg.aux;
            SEL_TAGLAT: rd_mux = cfg.taglat;
            SEL_DATLAT: rd_mux = cfg.datlat;
            SEL_FSTART: rd_mux = cfg.fstart;
            SEL_FEND:   rd_mux = cfg.fend;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            if (acc.rd) bus_rdata <= rd_mux;
            bad_access <= flag;
        end
    end

    // R12: the pulse follows exactly one flagged access
    assert_bad_follows_R12: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past(flag));

    // R3: identity read
    assert_id_read_R3: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.sel == SEL_ID) |=> bus_rdata == ID_WORD);

    // R2: maintenance range reports completion
    assert_maint_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.sel == SEL_MAINT) |=> bus_rdata == '0);

    // R6: enable register upper bits are zero
    assert_ctrl_bit0_R6: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.sel == SEL_CTRL) |=> bus_rdata[31:1] == '0);

    // R11: read data holds without an accepted read
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_cache_reg_stub.sv
`timescale 1ns/1ps
module sim_cache_reg_stub;

    typedef struct packed {
        logic [1:0]  op;     // 0 write, 1 read, 2 read+write
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_bad;
        logic [7:0]  req;
    } vec_t;

    localparam logic [1:0] WR = 2'd0, RD = 2'd1, BO = 2'd2;
    localparam int NV = 42;

    localparam vec_t VECS [NV] = '{
        '{RD, 32'h000,       32'h0,         32'h410000C8, 1'b0, 8'd3},  // R3
        '{WR, 32'h000,       32'hFFFFFFFF,  32'h0,        1'b1, 8'd3},  // R3 write flagged
        '{RD, 32'h000,       32'h0,         32'h410000C8, 1'b0, 8'd3},
        '{RD, 32'h104,       32'h0,         32'h02020000, 1'b0, 8'd8},  // R8
        '{RD, 32'h100,       32'h0,         32'h0,        1'b0, 8'd8},
        '{RD, 32'h108,       32'h0,         32'h0,        1'b0, 8'd8},
        '{RD, 32'h10C,       32'h0,         32'h0,        1'b0, 8'd8},
        '{RD, 32'hC00,       32'h0,         32'h0,        1'b0, 8'd8},
        '{RD, 32'hC04,       32'h0,         32'h0,        1'b0, 8'd8},
        '{WR, 32'h100,       32'hFFFFFFFF,  32'h0,        1'b0, 8'd6},  // R6
        '{RD, 32'h100,       32'h0,         32'h1,        1'b0, 8'd6},
        '{WR, 32'h108,       32'hA5A5A5A5,  32'h0,        1'b0, 8'd7},  // R7
        '{WR, 32'h10C,       32'h12345678,  32'h0,        1'b0, 8'd7},
        '{WR, 32'hC00,       32'hDEADBEEF,  32'h0,        1'b0, 8'd7},
        '{WR, 32'hC04,       32'h0F0F0F0F,  32'h0,        1'b0, 8'd7},
        '{RD, 32'h108,       32'h0,         32'hA5A5A5A5, 1'b0, 8'd7},
        '{RD, 32'h10C,       32'h0,         32'h12345678, 1'b0, 8'd7},
        '{RD, 32'hC04,       32'h0,         32'h0F0F0F0F, 1'b0, 8'd7},
        '{RD, 32'h00001C00,  32'h0,         32'hDEADBEEF, 1'b0, 8'd1},  // R1 alias
        '{WR, 32'hFFFFF108,  32'h11111111,  32'h0,        1'b0, 8'd1},
        '{RD, 32'h108,       32'h0,         32'h11111111, 1'b0, 8'd1},
        '{WR, 32'h730,       32'hFFFFFFFF,  32'h0,        1'b0, 8'd2},  // R2
        '{RD, 32'h730,       32'h0,         32'h0,        1'b0, 8'd2},
        '{RD, 32'h7FC,       32'h0,         32'h0,        1'b0, 8'd2},
        '{RD, 32'h800,       32'h0,         32'h0,        1'b1, 8'd10}, // R10 boundary
        '{RD, 32'h72C,       32'h0,         32'h0,        1'b1, 8'd10},
        '{RD, 32'hF40,       32'h0,         32'h0,        1'b0, 8'd9},  // R9
        '{WR, 32'hF60,       32'hFFFFFFFF,  32'h0,        1'b0, 8'd9},
        '{RD, 32'hF80,       32'h0,         32'h0,        1'b0, 8'd9},
        '{RD, 32'h200,       32'h0,         32'h0,        1'b1, 8'd10}, // R10
        '{WR, 32'h004,       32'hFFFFFFFF,  32'h0,        1'b1, 8'd5},  // R5 write flagged
        '{RD, 32'h004,       32'h0,         32'h1C100100, 1'b0, 8'd4},  // R4
        '{WR, 32'h104,       32'h00080000,  32'h0,        1'b0, 8'd13}, // R13 setup
        '{BO, 32'h004,       32'h0,         32'h0,        1'b1, 8'd13}, // R13 collision
        '{WR, 32'h104,       32'h0,         32'h0,        1'b0, 8'd13},
        '{RD, 32'h004,       32'h0,         32'h1C100100, 1'b0, 8'd13},
        '{WR, 32'h104,       32'h000F0000,  32'h0,        1'b0, 8'd4},
        '{RD, 32'h004,       32'h0,         32'h1C740740, 1'b0, 8'd4},
        '{WR, 32'h104,       32'h0,         32'h0,        1'b0, 8'd4},
        '{RD, 32'h004,       32'h0,         32'h1C740740, 1'b0, 8'd4},  // R4 sticky
        '{BO, 32'h100,       32'h0,         32'h0,        1'b0, 8'd11}, // R11 hold
        '{RD, 32'h100,       32'h0,         32'h0,        1'b0, 8'd13}  // R13 write took
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic        bad_access;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] last_rd;

    always #2.5 clk = ~clk;

    cache_reg_stub u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .bad_access (bad_access)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = (op != RD);
        bus_re    = (op != WR);
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset rdata", bus_rdata, 32'h0);
        chk("R8 reset flag", {31'b0, bad_access}, 32'h0);
        rst = 1'b0;
        last_rd = 32'h0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            access(VECS[i].op, VECS[i].addr, VECS[i].data);
            if (VECS[i].op == RD) last_rd = VECS[i].exp_rd;
            chk(tag, bus_rdata, last_rd);
            chk({tag, " flag"}, {31'b0, bad_access}, {31'b0, VECS[i].exp_bad});
        end

        // R12: pulse lasts one cycle, then drops with no access
        access(RD, 32'h300, 32'h0);
        chk("R12 pulse high", {31'b0, bad_access}, 32'h1);
        @(negedge clk);
        chk("R12 pulse low", {31'b0, bad_access}, 32'h0);
        access(WR, 32'h3F0, 32'h1);
        access(WR, 32'h3F4, 32'h1);
        chk("R12 back-to-back", {31'b0, bad_access}, 32'h1);
        @(negedge clk);
        chk("R12 back-to-back low", {31'b0, bad_access}, 32'h0);

        // R8 / R5: reset restores registers, type word survives
        access(WR, 32'h100, 32'h1);
        access(WR, 32'hC00, 32'h55AA55AA);
        access(WR, 32'h104, 32'h0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access(RD, 32'h104, 32'h0);
        chk("R8 aux after reset", bus_rdata, 32'h02020000);
        access(RD, 32'h100, 32'h0);
        chk("R8 ctrl after reset", bus_rdata, 32'h0);
        access(RD, 32'hC00, 32'h0);
        chk("R8 filter after reset", bus_rdata, 32'h0);
        access(RD, 32'h004, 32'h0);
        chk("R5 type kept over reset", bus_rdata, 32'h1C740740);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule